// File: doc/BRIEF.md
# OTG One-Shot Timeout Timer

This block is a host-programmable, single-shot countdown timer for a USB On-The-Go companion controller. Software writes one 32-bit word. The top bit of that word either starts a countdown or stops one, and the low 27 bits give the length of the countdown in cycles of the device clock. The device clock is nominally 60 MHz, but the block simply counts cycles of whatever clock it receives.

When the countdown runs out, the block produces a one-cycle timeout pulse for the interrupt aggregator, which maps it to its OTG-timeout source bit. In the same step the block clears its register to zero. A read returns the last word written, or zero once the timer has expired.

A new write always takes the place of whatever countdown is in progress. This also holds for a write that arrives in the very cycle the countdown would have expired.

Top module: `otg_timeout_timer`

## Requirements
- R1: After reset, rd_data reads 0 and timeout_pulse is low.
- R2: A write (wr_en high for one cycle) stores the full 32-bit wr_data word. From the cycle after the write edge, rd_data returns that whole word, bits 30:27 included.
- R3: A write with bit 31 set and count N = wr_data[26:0], N >= 1, raises timeout_pulse in exactly one cycle: the Nth cycle after the write edge, where the cycle directly following the write edge is cycle 1.
- R4: A count of 0 with bit 31 set behaves like a count of 1: the pulse comes in cycle 1.
- R5: A write with bit 31 set while a countdown runs discards the old countdown and restarts from the newly written count.
- R6: A write with bit 31 clear cancels any pending countdown. No pulse follows, and rd_data keeps the written word.
- R7: During the pulse cycle, rd_data still shows the written word. From the following cycle onward, rd_data reads 0.
- R8: timeout_pulse is never high in two consecutive cycles.
- R9: A write in the cycle a countdown would expire takes priority. No pulse occurs in that cycle, and the new word is stored.
- R10: Bits 30:27 of the written word have no effect on the countdown length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: bit 31 arms the timer, bits 26:0 hold the count |
| rd_data | output | 32 | Current register contents |
| timeout_pulse | output | 1 | One-cycle expiry event to the interrupt aggregator |

## Verification
The bound checker watches every cycle for these properties: the pulse stays one cycle wide, the register reads zero after a pulse, a write is reflected in rd_data on the next cycle, a disarming write is never followed by a pulse, and the register holds still while it is neither written nor expiring. Only the bench scenarios can show that the pulse lands in exactly the right cycle for a given count. The same is true of the zero-count case, the restart and cancel orderings, and the write that collides with expiry. The bench checks these against a queue of expected pulse cycles and readback values.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  typedef struct packed {
    logic load;
    logic arm;
  } tmr_cmd_t;
endpackage

// File: rtl/otg_tmr_rst_sync.sv
module otg_tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/otg_tmr_decode.sv
module otg_tmr_decode
  import otg_tmr_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             wr_en,
  input  logic             en_bit,
  input  logic [CNT_W-1:0] cnt_field,
  output tmr_cmd_t         cmd,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    cmd.load = wr_en;
    cmd.arm  = wr_en & en_bit;
    count    = cnt_field;
  end
endmodule

// File: rtl/otg_tmr_counter.sv
module otg_tmr_counter
  import otg_tmr_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;
  logic             cnt_en;

  // Next-state logic: a write always wins over the running countdown.
  always_comb begin
    at_last = (cnt_q <= ONE);
    expire  = (state_q == TMR_RUN) && at_last && !cmd.load;
    state_d = state_q;
    cnt_d   = cnt_q;
    if (cmd.load) begin
      state_d = cmd.arm ? TMR_RUN : TMR_IDLE;
      cnt_d   = cmd.arm ? count : '0;
    end else if (state_q == TMR_RUN) begin
      if (at_last) begin
        state_d = TMR_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    cnt_en = cmd.load || (state_q == TMR_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/otg_tmr_holdreg.sv
module otg_tmr_holdreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_en = load | clear;
    q_d  = load ? d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 27,
  parameter int EN_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout_pulse
);
  logic             rst_n_int;
  tmr_cmd_t         cmd;
  logic [CNT_W-1:0] count;
  logic             expire;

  otg_tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  otg_tmr_decode #(.CNT_W(CNT_W)) u_dec (
    .wr_en     (wr_en),
    .en_bit    (wr_data[EN_BIT]),
    .cnt_field (wr_data[CNT_W-1:0]),
    .cmd       (cmd),
    .count     (count)
  );

  otg_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cmd    (cmd),
    .count  (count),
    .expire (expire)
  );

  otg_tmr_holdreg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (cmd.load),
    .clear (expire),
    .d     (wr_data),
    .q     (rd_data)
  );

  assign timeout_pulse = expire;
endmodule

// File: rtl/otg_tmr_checker.sv
module otg_tmr_checker #(
  parameter int DATA_W = 32,
  parameter int EN_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              timeout_pulse
);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  assert_clear_after_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> (rd_data == '0));

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

  assert_cancel_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[EN_BIT]) |=> !timeout_pulse);

  assert_pulse_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> rd_data[EN_BIT]);

  assert_hold_when_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !timeout_pulse) |=> $stable(rd_data));

  assert_write_beats_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !timeout_pulse);
endmodule

bind otg_timeout_timer otg_tmr_checker #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_int),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .timeout_pulse (timeout_pulse)
);

// File: tb/test_otg_timeout_timer.sv
module test_otg_timeout_timer;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        timeout_pulse;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;
  bit done  = 0;
  bit after_pulse = 0;

  int          pend_cyc[$];
  logic [31:0] pend_val[$];

  otg_timeout_timer i_otg_timeout_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .timeout_pulse (timeout_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: drives a write in the cycle whose counter value is t (or later),
  // and records the expected pulse cycle and pre-clear value.
  task automatic write_at(input int t, input logic [31:0] val);
    int n;
    do @(negedge clk); while (cyc < t);
    #1;
    wr_en   = 1'b1;
    wr_data = val;
    pend_cyc.delete();
    pend_val.delete();
    if (val[31]) begin
      n = int'(val[26:0]);
      if (n == 0) n = 1;
      pend_cyc.push_back(cyc + n);
      pend_val.push_back(val);
    end
    @(negedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic write_now(input logic [31:0] val);
    write_at(0, val);
  endtask

  task automatic check_rd(input logic [31:0] exp, input string req);
    #1;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares pulses and readback against the expectation queue.
  always @(negedge clk) begin
    bit expected;
    #2;
    if (rst_n && !done) begin
      expected = (pend_cyc.size() > 0) && (pend_cyc[0] == cyc);
      if (after_pulse) chk(rd_data === 32'h0, "R7 clear after expiry", rd_data, 32'h0);
      after_pulse = 1'b0;
      if (expected || timeout_pulse) begin
        chk(timeout_pulse === expected, "R3 pulse timing", {31'h0, timeout_pulse}, {31'h0, expected});
        if (expected) begin
          chk(rd_data === pend_val[0], "R7 pre-clear value", rd_data, pend_val[0]);
          after_pulse = timeout_pulse;
          void'(pend_cyc.pop_front());
          void'(pend_val.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int c;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    idle(3);
    #1;
    chk(rd_data === 32'h0, "R1 reset rd_data", rd_data, 32'h0);
    chk(timeout_pulse === 1'b0, "R1 reset pulse", {31'h0, timeout_pulse}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R2 / R6: disarmed write is stored and never expires.
    write_now(32'h7800_1234);
    check_rd(32'h7800_1234, "R2 readback full word");
    idle(20);
    check_rd(32'h7800_1234, "R6 disarmed write holds");

    // R3: count 5.
    write_now(32'h8000_0005);
    idle(10);
    check_rd(32'h0, "R3 register cleared after expiry");

    // R4: zero count expires in cycle 1; count 1 likewise.
    write_now(32'h8000_0000);
    idle(4);
    write_now(32'h8000_0001);
    idle(4);
    check_rd(32'h0, "R4 cleared after short count");

    // R5: restart replaces a long countdown.
    write_now(32'h8000_0064);
    idle(10);
    write_now(32'h8000_0003);
    idle(120);
    check_rd(32'h0, "R5 restart then expiry");

    // R6: cancel a pending countdown.
    write_now(32'h8000_0010);
    idle(4);
    write_now(32'h0000_0000);
    idle(30);
    check_rd(32'h0, "R6 cancelled value");

    // R9: write in the expiry cycle wins.
    c = cyc + 1;
    write_at(c, 32'h8000_0004);
    write_at(c + 4, 32'h0000_00AA);
    check_rd(32'h0000_00AA, "R9 collision write stored");
    idle(10);
    check_rd(32'h0000_00AA, "R9 no later expiry");

    // R10: upper unused bits do not change the count.
    write_now(32'hF800_0003);
    idle(8);
    check_rd(32'h0, "R10 expiry with high bits set");

    // Longer countdown.
    write_now(32'h8000_03E8);
    idle(1010);

    chk(pend_cyc.size() == 0, "R3 all pulses seen", pend_cyc.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule